// File: doc/BRIEF.md
# Serial Autobaud Edge Timer

This block sits on the idle-high receive wire of an asynchronous serial port and works out the bit period from a known synchronisation character. The host starts every packet with the byte 0x0F. The byte is framed with one low start bit, eight data bits sent least-significant first, and one high stop bit. On the wire this gives exactly two rising edges: one where the start bit ends and one where the last data bit gives way to the stop bit. These two edges are eight bit times apart.

The block passes the wire through a synchroniser and waits for a falling edge. It then counts system clock cycles from the first rising edge to the last one. A character is complete once the line has stayed high for a fixed number of cycles. At that point the count is divided by eight, which is a right shift by three. The result goes out on a valid/ready port as the divisor for a downstream baud-rate generator.

A character that does not produce exactly two rising edges is discarded, and so is one whose count overflows or whose divisor would be zero. The sender must leave the line idle for at least the timeout after the synchronisation character so that the character is seen as complete. The outgoing divisor is held until the consumer takes it. While a divisor is waiting, any further result is dropped rather than queued; this is the only form of back-pressure.

Top module: `autobaud_edge_timer`

## Requirements
- R1: After reset, and for as long as the line stays idle high, div_valid is low.
- R2: For the character 0x0F (start bit 0, data least-significant bit first, stop bit 1) sent at a bit period of P clock cycles, the offered divisor equals floor(span/8), where span is the number of cycles between its first and last rising edges; this equals P for any P whose span fits the counter.
- R3: The receive input passes through two synchronising flops and an edge register. div_valid rises on the clock edge after the synchronised line has been high for IDLE_LIMIT consecutive cycles following the armed character.
- R4: A character with more than two rising edges before the idle timeout (for example 0x55) produces no divisor.
- R5: A character with fewer than two rising edges (for example 0xFF or 0xF0) produces no divisor.
- R6: The cycle counter saturates at 2^CNT_W-1; a span that reaches this value produces no divisor.
- R7: A span shorter than eight cycles, which would give a divisor of zero, produces no divisor.
- R8: While div_valid is high and div_ready is low, div_valid and div_data hold steady. div_valid falls on the clock edge after a cycle in which both are high.
- R9: A measurement that completes while an earlier divisor is still waiting is discarded, and the waiting divisor is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| div_ready | input | 1 | Consumer accepts the divisor |
| div_valid | output | 1 | Divisor offered |
| div_data | output | CNT_W-3 | Measured bit period in clock cycles |

## Verification
The assertions check several properties on every cycle. The offered divisor must stay stable while back-pressured and must never be zero. The saturated counter must stay pinned. A completed character must always return the measurer to its waiting state. The span must be captured from the counter at the second rising edge.

The bench scenarios are needed for the end-to-end properties. These are the exact divisor produced at several rates and at the widest representable span, and the rejection of characters with too many or too few edges. They also cover overflow and glitch rejection, and the dropping of a second result while the first waits. A behavioural model in the bench is compared on every cycle to pin down the offer latency.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
  typedef enum logic [1:0] {
    AB_IDLE  = 2'd0,
    AB_ARMED = 2'd1,
    AB_COUNT = 2'd2
  } ab_state_e;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ab_edge.sv
module ab_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= level_i;
  end

  assign rise_o = level_i & ~prev;
  assign fall_o = ~level_i & prev;
endmodule

// File: rtl/ab_measure.sv
module ab_measure
  import autobaud_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int SPAN_SHIFT = 3,
  parameter int IDLE_LIMIT = 20000,
  parameter int DIV_W      = CNT_W - SPAN_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             ok_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int               HI_W    = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [HI_W-1:0]  HI_LIM  = HI_W'(IDLE_LIMIT);

  ab_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] span;
  logic             span_sat;
  logic [1:0]       edges;
  logic [HI_W-1:0]  hi;
  logic             finish;

  assign finish = (st == AB_COUNT) && (hi == HI_LIM);
  assign div_o  = span[CNT_W-1:SPAN_SHIFT];
  assign ok_o   = finish && (edges == 2'd2) && !span_sat && (div_o != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= AB_IDLE;
      cnt      <= '0;
      span     <= '0;
      span_sat <= 1'b0;
      edges    <= '0;
      hi       <= '0;
    end else begin
      unique case (st)
        AB_IDLE: begin
          if (fall_i) st <= AB_ARMED;
        end
        AB_ARMED: begin
          if (rise_i) begin
            st       <= AB_COUNT;
            cnt      <= CNT_W'(1);
            edges    <= 2'd1;
            hi       <= HI_W'(1);
            span     <= '0;
            span_sat <= 1'b0;
          end
        end
        AB_COUNT: begin
          if (finish) begin
            st <= AB_IDLE;
          end else begin
            if (rise_i) begin
              if (edges == 2'd1) begin
                span     <= cnt;
                span_sat <= (cnt == CNT_MAX);
              end
              if (edges != 2'd3) edges <= edges + 2'd1;
            end
            if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
            if (!level_i)         hi <= '0;
            else if (hi != HI_LIM) hi <= hi + HI_W'(1);
          end
        end
        default: st <= AB_IDLE;
      endcase
    end
  end

  // R2: span taken from the running count at the second rising edge
  p_span_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == AB_COUNT && !finish && rise_i && edges == 2'd1) |=> (span == $past(cnt)));

  // R6: saturated counter stays pinned while counting continues
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == AB_COUNT && !finish && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R3: a completed character always returns to waiting
  p_finish_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (st == AB_IDLE));
endmodule

// File: rtl/ab_hold.sv
module ab_hold #(
  parameter int DIV_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [DIV_W-1:0] data_o
);
  logic load_fire;
  assign load_fire = load_i && !valid_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (load_fire) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
      end
    end
  end

  // R8: back-pressured output holds
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  // R9: a new result arriving while one waits does not disturb it
  p_drop_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && load_i) |=> (data_o == $past(data_o)));

  // R7: an offered divisor is never zero
  p_div_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (data_o != '0));
endmodule

// File: rtl/autobaud_edge_timer.sv
module autobaud_edge_timer #(
  parameter int CNT_W       = 20,
  parameter int SPAN_SHIFT  = 3,
  parameter int IDLE_LIMIT  = 20000,
  parameter int SYNC_STAGES = 2,
  localparam int DIV_W      = CNT_W - SPAN_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             div_ready,
  output logic             div_valid,
  output logic [DIV_W-1:0] div_data
);
  logic             line_s;
  logic             rise;
  logic             fall;
  logic             meas_ok;
  logic [DIV_W-1:0] meas_div;

  ab_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(line_s)
  );

  ab_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(line_s), .rise_o(rise), .fall_o(fall)
  );

  ab_measure #(
    .CNT_W(CNT_W), .SPAN_SHIFT(SPAN_SHIFT), .IDLE_LIMIT(IDLE_LIMIT), .DIV_W(DIV_W)
  ) u_measure (
    .clk(clk), .rst_n(rst_n), .level_i(line_s), .rise_i(rise), .fall_i(fall),
    .ok_o(meas_ok), .div_o(meas_div)
  );

  ab_hold #(.DIV_W(DIV_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(meas_ok), .data_i(meas_div),
    .ready_i(div_ready), .valid_o(div_valid), .data_o(div_data)
  );
endmodule

// File: tb/tb_autobaud_edge_timer.sv
module tb_autobaud_edge_timer;
  localparam int CNT_W = 12;
  localparam int LIM   = 2500;
  localparam int DIV_W = CNT_W - 3;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int GAP   = LIM + 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic rdy = 1'b1;
  logic             div_valid;
  logic [DIV_W-1:0] div_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R3";
  int got[$];

  always #2 clk = ~clk;

  autobaud_edge_timer #(.CNT_W(CNT_W), .IDLE_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx), .div_ready(rdy),
    .div_valid(div_valid), .div_data(div_data)
  );

  // behavioural reference model
  int m_s1 = 1, m_s2 = 1, m_prev = 1;
  int mst = 0, mcnt = 0, mspan = 0, msat = 0, medg = 0, mhi = 0;
  int mval = 0, mdat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1;
      mst = 0; mcnt = 0; mspan = 0; msat = 0; medg = 0; mhi = 0;
      mval = 0; mdat = 0;
    end else begin
      int rise_m, fall_m, fin, pre;
      rise_m = (m_s2 == 1 && m_prev == 0) ? 1 : 0;
      fall_m = (m_s2 == 0 && m_prev == 1) ? 1 : 0;
      fin = (mst == 2 && mhi == LIM) ? 1 : 0;
      pre = mval;
      if (pre == 1 && rdy) mval = 0;
      if (fin == 1 && medg == 2 && msat == 0 && (mspan / 8) != 0 && pre == 0) begin
        mval = 1;
        mdat = mspan / 8;
      end
      if (mst == 0) begin
        if (fall_m == 1) mst = 1;
      end else if (mst == 1) begin
        if (rise_m == 1) begin
          mst = 2; mcnt = 1; medg = 1; mhi = 1; mspan = 0; msat = 0;
        end
      end else begin
        if (fin == 1) mst = 0;
        else begin
          if (rise_m == 1) begin
            if (medg == 1) begin mspan = mcnt; msat = (mcnt == CMAX) ? 1 : 0; end
            if (medg < 3) medg++;
          end
          if (mcnt < CMAX) mcnt++;
          if (m_s2 == 0) mhi = 0;
          else if (mhi < LIM) mhi++;
        end
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = rx;
    end
  end

  // per-cycle comparison and capture of handshakes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (div_valid !== (mval == 1) || (mval == 1 && int'(div_data) != mdat)) begin
        bad++;
        $display("FAIL %s cycle compare: valid=%0b data=%0d expected valid=%0d data=%0d",
                 cur_req, div_valid, div_data, mval, mdat);
      end
      if (div_valid && rdy) got.push_back(int'(div_data));
    end
  end

  task automatic check(string req, bit cond, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_result(string req, int expn, int expv);
    int a;
    a = (got.size() > 0) ? got[0] : -1;
    check(req, got.size() == expn && (expn == 0 || got[0] == expv),
          (expn == 0) ? got.size() : a, (expn == 0) ? 0 : expv);
    got.delete();
  endtask

  task automatic send_byte(logic [7:0] b, int p);
    for (int i = 0; i < 10; i++) begin
      rx = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      repeat (p) @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    rx = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    cur_req = "R1";
    check("R1 valid after reset", div_valid == 1'b0, div_valid, 0);
    idle(50);
    check("R1 idle line", div_valid == 1'b0 && got.size() == 0, div_valid, 0);

    // R2 / R3: several bit periods
    cur_req = "R3";
    send_byte(8'h0F, 20);  idle(GAP); check_result("R2 P=20", 1, 20);
    send_byte(8'h0F, 37);  idle(GAP); check_result("R2 P=37", 1, 37);
    send_byte(8'h0F, 100); idle(GAP); check_result("R2 P=100", 1, 100);
    send_byte(8'h0F, 511); idle(GAP); check_result("R2 widest P=511", 1, 511);

    // R4: too many edges
    cur_req = "R4";
    send_byte(8'h55, 20); idle(GAP); check_result("R4 0x55 rejected", 0, 0);

    // R5: too few edges
    cur_req = "R5";
    send_byte(8'hFF, 20); idle(GAP); check_result("R5 0xFF rejected", 0, 0);
    send_byte(8'hF0, 30); idle(GAP); check_result("R5 0xF0 rejected", 0, 0);

    // R6: counter overflow
    cur_req = "R6";
    send_byte(8'h0F, 520); idle(GAP); check_result("R6 saturated span", 0, 0);

    // R7: glitch giving zero divisor
    cur_req = "R7";
    rx = 1'b0; repeat (3) @(negedge clk);
    rx = 1'b1; repeat (3) @(negedge clk);
    rx = 1'b0; repeat (3) @(negedge clk);
    idle(GAP); check_result("R7 zero divisor rejected", 0, 0);

    // R8 / R9: back-pressure and dropping
    cur_req = "R8";
    rdy = 1'b0;
    send_byte(8'h0F, 20); idle(GAP);
    check("R8 held valid", div_valid == 1'b1, div_valid, 1);
    check("R8 held data", div_data == DIV_W'(20), div_data, 20);
    cur_req = "R9";
    send_byte(8'h0F, 30); idle(GAP);
    check("R9 pending data unchanged", div_valid && div_data == DIV_W'(20), div_data, 20);
    rdy = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 cleared after handshake", div_valid == 1'b0, div_valid, 0);
    idle(20);
    check_result("R9 single delivery", 1, 20);

    done = 1;
    summary();
    $finish;
  end
endmodule